// File: doc/BRIEF.md
# Radix-2² Delay-Feedback FFT Stage

This block is one stage of a streaming FFT pipeline built on the radix-2² single-path delay-feedback scheme. It accepts one complex sample per clock, qualified by a valid strobe, and emits one complex sample per clock two cycles later. The stage holds two radix-2 butterfly elements in series. The first keeps a feedback delay line of `L` samples and the second keeps one of `L/2` samples. For the first stage of an N-point transform, `L = N/2`. The trivial multiplication by -j is folded into the second element as a swap of real and imaginary parts with one negation.

One binary counter of `log2(L)+1` bits is the only control. It counts accepted samples. Each element has two phases. In FILL, the element stores the incoming sample and releases its oldest stored sample unchanged. In COMBINE, it releases the scaled sum of its oldest stored sample and the incoming sample, and stores their scaled difference. The transition FILL→COMBINE happens when the element's counter bit rises, and COMBINE→FILL when it falls. Each element halves its results. The first rounds half-up and the second truncates, so the two biases offset each other across the stage. A register sits between the elements and another at the stage output. The control bits travel with the data through the first of these registers. The non-trivial twiddle multiply that follows a stage is not part of this block.

Top module: `r22_sdf_stage`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two clock cycles; output data changes only on the cycle that `out_valid` rises or stays high.
- R2: The control counter starts at 0 after reset and advances by one, modulo `2L`, only on cycles with `in_valid` high. Cycles without `in_valid` change neither the counter nor either delay line.
- R3: The first element is in COMBINE when counter bit `log2(L)` of the sample's count is 1 and in FILL when it is 0. FILL outputs the sample stored `L` accepted samples earlier and stores the input. COMBINE outputs the scaled sum of stored and input samples and stores their scaled difference.
- R4: The first element halves by adding 1 and then shifting right arithmetically (round half-up). A result above the largest 16-bit value is clamped to 32767, for example a stored real part of 32767 combined with an input of -32768.
- R5: The second element behaves as R3 with depth `L/2`. It is controlled by bit `log2(L)-1` of the count that travelled with the sample, and it halves by arithmetic right shift (truncation toward minus infinity).
- R6: A sample entering the second element whose count has bit `log2(L)` = 0 and bit `log2(L)-1` = 1 is rotated by -j before the butterfly, meaning (re, im) becomes (im, -re).
- R7: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` = 0 and zero output data. Both delay lines and the counter are cleared, so the first FILL outputs after reset are zero.
- R8: While `out_valid` is low, `out_re` and `out_im` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies the input sample |
| in_re | input | DW | Input real part, two's complement |
| in_im | input | DW | Input imaginary part, two's complement |
| out_valid | output | 1 | Qualifies the output sample |
| out_re | output | DW | Output real part, two's complement |
| out_im | output | DW | Output imaginary part, two's complement |

## Verification
Four properties are checked on every cycle: the two-cycle valid latency, the counter holding on idle cycles and stepping on accepted ones, the output holding while invalid, and the cleared outputs after reset. The arithmetic cannot be checked that way. This covers the FILL/COMBINE order of each element, the half-up versus truncating rounding, the clamp at the positive limit and the place where the -j rotation applies. These show only in the bench's scenarios, which compare every output bit-for-bit against a sample-by-sample model. The scenarios include back-to-back blocks, gapped input, extreme values and a reset in mid-block.

// File: rtl/r22_sdf_pkg.sv
package r22_sdf_pkg;

    // Phase of one butterfly element, taken straight from its counter bit.
    typedef enum logic {
        PH_FILL    = 1'b0,
        PH_COMBINE = 1'b1
    } bf_phase_e;

    // Halving rule applied by a butterfly element.
    typedef enum logic {
        RND_HALF_UP = 1'b0,
        RND_TRUNC   = 1'b1
    } rnd_mode_e;

endpackage

// File: rtl/r22_delay_line.sv
module r22_delay_line #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] wr_re,
    input  logic signed [DW-1:0] wr_im,
    output logic signed [DW-1:0] head_re,
    output logic signed [DW-1:0] head_im
);

    logic signed [DW-1:0] re_q [DEPTH];
    logic signed [DW-1:0] im_q [DEPTH];

    // Entry 0 is the newest sample; entry DEPTH-1 is the oldest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                re_q[i] <= '0;
                im_q[i] <= '0;
            end
        end else if (shift_en) begin
            re_q[0] <= wr_re;
            im_q[0] <= wr_im;
            for (int i = 1; i < DEPTH; i++) begin
                re_q[i] <= re_q[i-1];
                im_q[i] <= im_q[i-1];
            end
        end
    end

    assign head_re = re_q[DEPTH-1];
    assign head_im = im_q[DEPTH-1];

endmodule

// File: rtl/r22_butterfly.sv
module r22_butterfly
    import r22_sdf_pkg::*;
#(
    parameter int        DW      = 16,
    parameter int        DEPTH   = 8,
    parameter rnd_mode_e RND     = RND_HALF_UP,
    parameter bit        HAS_ROT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  bf_phase_e            phase,
    input  logic                 rot,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);

    localparam int SW = DW + 2;
    localparam logic signed [SW-1:0] MAXW = {3'b000, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] MINW = {3'b111, {(DW-1){1'b0}}};

    logic signed [DW-1:0] head_re, head_im;
    logic signed [DW-1:0] wr_re, wr_im;
    logic signed [SW-1:0] a_re, a_im, b_re, b_im;
    logic signed [SW-1:0] bias;
    logic signed [SW-1:0] sum_re, sum_im, dif_re, dif_im;
    logic signed [DW-1:0] sum_re_h, sum_im_h, dif_re_h, dif_im_h;

    function automatic logic signed [SW-1:0] sext(input logic signed [DW-1:0] x);
        return {{2{x[DW-1]}}, x};
    endfunction

    function automatic logic signed [DW-1:0] clamp(input logic signed [SW-1:0] x);
        if (x > MAXW) return MAXW[DW-1:0];
        if (x < MINW) return MINW[DW-1:0];
        return x[DW-1:0];
    endfunction

    r22_delay_line #(.DW(DW), .DEPTH(DEPTH)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(en),
        .wr_re   (wr_re),
        .wr_im   (wr_im),
        .head_re (head_re),
        .head_im (head_im)
    );

    assign a_re = sext(head_re);
    assign a_im = sext(head_im);

    // R6: trivial -j rotation, (re, im) -> (im, -re), only in the element that has it
    generate
        if (HAS_ROT) begin : g_rot
            assign b_re = rot ? sext(in_im)  : sext(in_re);
            assign b_im = rot ? -sext(in_re) : sext(in_im);
        end else begin : g_norot
            logic unused_rot;
            assign unused_rot = rot;
            assign b_re = sext(in_re);
            assign b_im = sext(in_im);
        end
    endgenerate

    // R4 half-up adds one before the shift, R5 truncation adds nothing
    generate
        if (RND == RND_HALF_UP) begin : g_half_up
            assign bias = SW'(1);
        end else begin : g_trunc
            assign bias = '0;
        end
    endgenerate

    assign sum_re = (a_re + b_re + bias) >>> 1;
    assign sum_im = (a_im + b_im + bias) >>> 1;
    assign dif_re = (a_re - b_re + bias) >>> 1;
    assign dif_im = (a_im - b_im + bias) >>> 1;

    assign sum_re_h = clamp(sum_re);
    assign sum_im_h = clamp(sum_im);
    assign dif_re_h = clamp(dif_re);
    assign dif_im_h = clamp(dif_im);

    // R3/R5: FILL passes the stored sample out, COMBINE emits sum and stores difference
    always_comb begin
        unique case (phase)
            PH_FILL: begin
                out_re = head_re;
                out_im = head_im;
                wr_re  = b_re[DW-1:0];
                wr_im  = b_im[DW-1:0];
            end
            PH_COMBINE: begin
                out_re = sum_re_h;
                out_im = sum_im_h;
                wr_re  = dif_re_h;
                wr_im  = dif_im_h;
            end
            default: begin
                out_re = head_re;
                out_im = head_im;
                wr_re  = b_re[DW-1:0];
                wr_im  = b_im[DW-1:0];
            end
        endcase
    end

endmodule

// File: rtl/r22_sdf_ctrl.sv
module r22_sdf_ctrl
    import r22_sdf_pkg::*;
#(
    parameter int L = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv,
    output logic [$clog2(L):0]         cnt,
    output bf_phase_e                  bf1_phase,
    output bf_phase_e                  bf2_phase,
    output logic                       bf2_rot,
    output logic                       mid_valid
);

    localparam int LOG2L = $clog2(L);
    localparam int CW    = LOG2L + 1;

    logic [CW-1:0] cnt_q;
    logic          tag_hi_q;
    logic          tag_lo_q;
    logic          mid_v_q;

    // R2: the counter is the whole control state; it moves only on accepted samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // The two control bits travel with the data through the mid register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_hi_q <= 1'b0;
            tag_lo_q <= 1'b0;
            mid_v_q  <= 1'b0;
        end else begin
            mid_v_q <= adv;
            if (adv) begin
                tag_hi_q <= cnt_q[LOG2L];
                tag_lo_q <= cnt_q[LOG2L-1];
            end
        end
    end

    assign cnt       = cnt_q;
    assign bf1_phase = bf_phase_e'(cnt_q[LOG2L]);
    assign bf2_phase = bf_phase_e'(tag_lo_q);
    assign bf2_rot   = !tag_hi_q && tag_lo_q;
    assign mid_valid = mid_v_q;

endmodule

// File: rtl/r22_sdf_stage.sv
module r22_sdf_stage
    import r22_sdf_pkg::*;
#(
    parameter int DW = 16,
    parameter int L  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);

    localparam int LOG2L = $clog2(L);
    localparam int CW    = LOG2L + 1;
    localparam int L2    = L / 2;

    logic [CW-1:0]        cnt;
    bf_phase_e            bf1_phase, bf2_phase;
    logic                 bf2_rot;
    logic                 mid_valid;
    logic signed [DW-1:0] bf1_re, bf1_im;
    logic signed [DW-1:0] mid_re_q, mid_im_q;
    logic signed [DW-1:0] bf2_re, bf2_im;
    logic                 out_v_q;
    logic signed [DW-1:0] out_re_q, out_im_q;

    r22_sdf_ctrl #(.L(L)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (in_valid),
        .cnt      (cnt),
        .bf1_phase(bf1_phase),
        .bf2_phase(bf2_phase),
        .bf2_rot  (bf2_rot),
        .mid_valid(mid_valid)
    );

    r22_butterfly #(.DW(DW), .DEPTH(L), .RND(RND_HALF_UP), .HAS_ROT(1'b0)) u_bf1 (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .phase (bf1_phase),
        .rot   (1'b0),
        .in_re (in_re),
        .in_im (in_im),
        .out_re(bf1_re),
        .out_im(bf1_im)
    );

    // Register between the elements; it holds while no sample is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_re_q <= '0;
            mid_im_q <= '0;
        end else if (in_valid) begin
            mid_re_q <= bf1_re;
            mid_im_q <= bf1_im;
        end
    end

    r22_butterfly #(.DW(DW), .DEPTH(L2), .RND(RND_TRUNC), .HAS_ROT(1'b1)) u_bf2 (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mid_valid),
        .phase (bf2_phase),
        .rot   (bf2_rot),
        .in_re (mid_re_q),
        .in_im (mid_im_q),
        .out_re(bf2_re),
        .out_im(bf2_im)
    );

    // Stage output register (R1 latency, R8 hold)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v_q  <= 1'b0;
            out_re_q <= '0;
            out_im_q <= '0;
        end else begin
            out_v_q <= mid_valid;
            if (mid_valid) begin
                out_re_q <= bf2_re;
                out_im_q <= bf2_im;
            end
        end
    end

    assign out_valid = out_v_q;
    assign out_re    = out_re_q;
    assign out_im    = out_im_q;

endmodule

// File: rtl/r22_sdf_stage_chk.sv
module r22_sdf_stage_chk #(
    parameter int DW = 16,
    parameter int CW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_re,
    input logic signed [DW-1:0] out_im,
    input logic [CW-1:0]        cnt
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (cnt == CW'($past(cnt) + 1'b1)));

    p_reset_r7: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_re == '0 && out_im == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd1) && !out_valid) |-> ($stable(out_re) && $stable(out_im)));

endmodule

bind r22_sdf_stage r22_sdf_stage_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_re   (out_re),
    .out_im   (out_im),
    .cnt      (cnt)
);

// File: tb/test_r22_sdf_stage.sv
module test_r22_sdf_stage;

    localparam int DW    = 16;
    localparam int L     = 8;
    localparam int L2    = L / 2;
    localparam int LOG2L = 3;
    localparam int NBLK  = 2 * L;

    localparam int STIM_RE [16] = '{ 1200, -3400,  5600, 30000, -29000,  77, -1, 0,
                                     15000, -15001, 255, -256, 8191, -8192, 32000, -32000 };
    localparam int STIM_IM [16] = '{ -700,  2100, -9999,  4, 31000, -31000, 12, 13,
                                     -1, 1, 20000, -20000, 444, -555, 6666, -7777 };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_re = '0;
    logic signed [DW-1:0] in_im = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_re, out_im;

    int n_checks = 0;
    int n_fail = 0;
    string cur_tag = "R3 R5 R6";

    int f1re [L];  int f1im [L];
    int f2re [L2]; int f2im [L2];
    int mcnt = 0;

    bit e0_v = 0, e1_v = 0;
    int e0_re = 0, e0_im = 0, e1_re = 0, e1_im = 0;
    bit hold_armed = 0;
    int last_re = 0, last_im = 0;

    always #5 clk = ~clk;

    r22_sdf_stage #(.DW(DW), .L(L)) i_r22_sdf_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    function automatic int clamp16(input int x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < L; i++) begin f1re[i] = 0; f1im[i] = 0; end
        for (int i = 0; i < L2; i++) begin f2re[i] = 0; f2im[i] = 0; end
        mcnt = 0;
    endtask

    // Behavioural stage built from R3..R6, one accepted sample at a time
    task automatic model(input int xr, input int xi, output int yr, output int yi);
        bit hi, lo;
        int ar, ai, o1r, o1i, br, bi, nr, ni, t;
        hi = mcnt[LOG2L];
        lo = mcnt[LOG2L-1];
        ar = f1re[L-1]; ai = f1im[L-1];
        if (!hi) begin
            o1r = ar; o1i = ai; nr = xr; ni = xi;
        end else begin
            o1r = clamp16((ar + xr + 1) >>> 1); o1i = clamp16((ai + xi + 1) >>> 1);
            nr  = clamp16((ar - xr + 1) >>> 1); ni  = clamp16((ai - xi + 1) >>> 1);
        end
        for (int i = L - 1; i > 0; i--) begin f1re[i] = f1re[i-1]; f1im[i] = f1im[i-1]; end
        f1re[0] = nr; f1im[0] = ni;
        br = o1r; bi = o1i;
        if (!hi && lo) begin t = br; br = bi; bi = -t; end
        ar = f2re[L2-1]; ai = f2im[L2-1];
        if (!lo) begin
            yr = ar; yi = ai; nr = br; ni = bi;
        end else begin
            yr = clamp16((ar + br) >>> 1); yi = clamp16((ai + bi) >>> 1);
            nr = clamp16((ar - br) >>> 1); ni = clamp16((ai - bi) >>> 1);
        end
        for (int i = L2 - 1; i > 0; i--) begin f2re[i] = f2re[i-1]; f2im[i] = f2im[i-1]; end
        f2re[0] = nr; f2im[0] = ni;
        mcnt = (mcnt + 1) % NBLK;
    endtask

    task automatic step(input bit v, input int xr, input int xi);
        int yr, yi;
        @(negedge clk);
        check("R1 out_valid latency", int'(out_valid), int'(e1_v));
        if (e1_v) begin
            check({cur_tag, " out_re"}, int'(out_re), e1_re);
            check({cur_tag, " out_im"}, int'(out_im), e1_im);
        end else if (hold_armed) begin
            check("R8 hold re", int'(out_re), last_re);
            check("R8 hold im", int'(out_im), last_im);
        end
        last_re = int'(out_re); last_im = int'(out_im); hold_armed = 1;
        e1_v = e0_v; e1_re = e0_re; e1_im = e0_im;
        e0_v = v;
        if (v) begin model(xr, xi, yr, yi); e0_re = yr; e0_im = yi; end
        in_valid = v; in_re = DW'(xr); in_im = DW'(xi);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0;
        repeat (2) @(negedge clk);
        check("R7 reset out_valid", int'(out_valid), 0);
        check("R7 reset out_re", int'(out_re), 0);
        check("R7 reset out_im", int'(out_im), 0);
        model_reset();
        e0_v = 0; e1_v = 0; hold_armed = 0;
        rst_n = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R1 watchdog: actual %0d cycles expected fewer than %0d", 20000, 20000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // Table walk: three back-to-back blocks, the middle one negated (R3 R5 R6, R7 zero fill)
        cur_tag = "R3 R5 R6 R7";
        for (int k = 0; k < 3 * NBLK; k++) begin
            int s;
            s = (k / NBLK == 1) ? -1 : 1;
            step(1'b1, s * STIM_RE[k % NBLK], s * STIM_IM[k % NBLK]);
        end
        repeat (3) step(1'b0, 0, 0);

        // Gapped input: idle cycles must not move the counter or the lines (R2, R8)
        cur_tag = "R2";
        for (int k = 0; k < 2 * NBLK; k++) begin
            step(1'b1, STIM_IM[k % NBLK], STIM_RE[(k + 5) % NBLK]);
            if (k % 3 != 2) step(1'b0, 12345, -12345);
        end
        repeat (3) step(1'b0, 0, 0);

        // Extremes: half-up clamp at the positive limit (R4)
        cur_tag = "R4";
        for (int k = 0; k < 3 * NBLK; k++) begin
            int xr, xi;
            xr = ((k % NBLK) < L) ? 32767 : -32768;
            xi = ((k % NBLK) < L) ? -32768 : 32767;
            if (k % 5 == 4) xr = -32768;
            step(1'b1, xr, xi);
        end
        repeat (3) step(1'b0, 0, 0);

        // Reset in mid-block, then restart from a cleared state (R7)
        for (int k = 0; k < 5; k++) step(1'b1, STIM_RE[k], STIM_IM[k]);
        do_reset();
        cur_tag = "R7 R3 R5 R6";
        for (int k = 0; k < 2 * NBLK; k++) step(1'b1, STIM_RE[(k * 3) % NBLK], STIM_IM[(k * 7) % NBLK]);
        repeat (3) step(1'b0, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule